// File: doc/BRIEF.md
# Unrolled Pipelined AES-128 Encryption Engine

This block encrypts 128-bit blocks with AES-128. The ten cipher rounds are laid out in hardware one after another, each behind its own register stage, so a fresh plaintext and key pair can enter on every clock edge. Round keys are never stored as a precomputed table. Each round stage derives its round key from the key that arrived alongside the data, and it registers that new key next to the state it has just transformed. Every block therefore carries its own key schedule down the pipe, and blocks with different keys can follow each other with no gap.

An input register stage captures the qualifier, the raw key and the plaintext XOR key (the initial key addition). The ten round stages follow it. A valid bit travels with every stage, so the output qualifier shows exactly which output cycles hold ciphertext. There is no backpressure: a result appears a fixed number of edges after its input was captured, whether or not anything is ready for it.

Top module: `aes128_pipe_enc`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_text is all zeros. After rst_n rises, out_valid stays 0 until a block captured after reset has had time to reach the output.
- R2: A block captured at a rising edge n with in_valid high shows out_valid high with its ciphertext right after edge n+10, which is 11 edges counting the capturing edge. Results leave in the order the blocks entered.
- R3: If in_valid is high on consecutive edges, out_valid is high on the same number of consecutive output cycles, one ciphertext per clock.
- R4: If in_valid is low at edge n, out_valid is low right after edge n+10. Whatever is on in_key and in_text at that edge has no effect on any output.
- R5: Byte k of a 128-bit value sits at bits [127-8k:120-8k]. The state is column-major: byte 4c+r is row r, column c. For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R6: Each block is encrypted under the key that entered with it, including back-to-back blocks whose keys differ.
- R7: Round key i comes from round key i-1. Rotate its last word left by one byte, pass each byte through the S-box, and XOR the round constant into the top byte. The round constants for rounds 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36. Then chain the XOR across the four words.
- R8: Rounds 1 to 9 apply byte substitution, row rotation, column mixing and key addition. Round 10 leaves out column mixing. Row r is rotated left by r bytes. Column mixing multiplies each column by the circulant matrix with first row {02, 03, 01, 01}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when in_key and in_text carry a block to encrypt |
| in_key | input | 128 | Cipher key for this block |
| in_text | input | 128 | Plaintext block |
| out_valid | output | 1 | High when out_text holds a finished ciphertext |
| out_text | output | 128 | Ciphertext block |

## Verification
The bench builds the engine with the package defaults: a 128-bit block, 16 bytes in four columns and ten rounds, which puts eleven register stages between the pins. That depth lets a run of two dozen back-to-back blocks with alternating keys keep every stage busy with a different key at once, so a schedule that slips by one stage yields wrong ciphertext at once. Published known-answer vectors pin down the byte ordering, the round constants and the missing final mixing step. Streams that are gapped on purpose, with junk driven on the data pins during the gaps, expose any leak of idle cycles into the valid sequence.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    localparam int BLOCK_W    = 128;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int NUM_BYTES  = BLOCK_W / BYTE_W;
    localparam int NUM_COLS   = BLOCK_W / WORD_W;
    localparam int NUM_ROWS   = NUM_BYTES / NUM_COLS;
    localparam int NUM_ROUNDS = 10;
    localparam int PIPE_LAT   = NUM_ROUNDS + 1;

    typedef logic [BLOCK_W-1:0] block_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [BYTE_W-1:0]  byte_t;

    typedef struct packed {
        logic   vld;
        block_t state;
        block_t rkey;
    } stage_t;

    function automatic byte_t get_byte(input block_t b, input int idx);
        return b[BLOCK_W-1-BYTE_W*idx -: BYTE_W];
    endfunction

    function automatic byte_t xtime(input byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t p;
        acc = '0;
        p   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // a^254 is the field inverse; zero maps to zero
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p;
        byte_t r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t x, input int n);
        return byte_t'(x << n) | byte_t'(x >> (BYTE_W - n));
    endfunction

    function automatic byte_t sbox(input byte_t b);
        byte_t x;
        x = gf_inv(b);
        return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ 8'h63;
    endfunction

    function automatic word_t sub_word(input word_t w);
        word_t o;
        for (int i = 0; i < WORD_W / BYTE_W; i++)
            o[BYTE_W*i +: BYTE_W] = sbox(w[BYTE_W*i +: BYTE_W]);
        return o;
    endfunction

    function automatic block_t sub_bytes(input block_t b);
        block_t o;
        for (int i = 0; i < NUM_BYTES; i++)
            o[BLOCK_W-1-BYTE_W*i -: BYTE_W] = sbox(get_byte(b, i));
        return o;
    endfunction

    function automatic block_t shift_rows(input block_t b);
        block_t o;
        for (int c = 0; c < NUM_COLS; c++)
            for (int r = 0; r < NUM_ROWS; r++)
                o[BLOCK_W-1-BYTE_W*(NUM_ROWS*c+r) -: BYTE_W] =
                    get_byte(b, NUM_ROWS*((c + r) % NUM_COLS) + r);
        return o;
    endfunction

    function automatic word_t mix_word(input word_t col);
        byte_t a0, a1, a2, a3;
        a0 = col[31:24];
        a1 = col[23:16];
        a2 = col[15:8];
        a3 = col[7:0];
        return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
                xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
    endfunction

    function automatic block_t mix_columns(input block_t b);
        block_t o;
        for (int c = 0; c < NUM_COLS; c++)
            o[BLOCK_W-1-WORD_W*c -: WORD_W] = mix_word(b[BLOCK_W-1-WORD_W*c -: WORD_W]);
        return o;
    endfunction

    function automatic byte_t fold_word(input word_t w);
        return w[31:24] ^ w[23:16] ^ w[15:8] ^ w[7:0];
    endfunction

    function automatic byte_t rcon_of(input int rnd);
        byte_t x;
        x = 8'h01;
        for (int i = 1; i < rnd; i++) x = xtime(x);
        return x;
    endfunction

endpackage

// File: rtl/aes128_key_step.sv
module aes128_key_step
    import aes128_pkg::*;
#(
    parameter byte_t RCON = 8'h01
) (
    input  block_t key_i,
    output block_t key_o
);

    word_t w0, w1, w2, w3;
    word_t tw_d;
    word_t n0_d, n1_d, n2_d, n3_d;

    always_comb begin
        w0   = key_i[127:96];
        w1   = key_i[95:64];
        w2   = key_i[63:32];
        w3   = key_i[31:0];
        tw_d = sub_word({w3[23:0], w3[31:24]}) ^ {RCON, 24'h000000};
        n0_d = w0 ^ tw_d;
        n1_d = n0_d ^ w1;
        n2_d = n1_d ^ w2;
        n3_d = n2_d ^ w3;
    end

    assign key_o = {n0_d, n1_d, n2_d, n3_d};

endmodule

// File: rtl/aes128_round.sv
module aes128_round
    import aes128_pkg::*;
#(
    parameter bit LAST = 1'b0
) (
    input  block_t state_i,
    input  block_t rkey_i,
    output block_t state_o
);

    block_t shifted_d;
    block_t mixed_d;

    always_comb shifted_d = shift_rows(sub_bytes(state_i));

    generate
        if (LAST) begin : g_final
            assign mixed_d = shifted_d;
        end else begin : g_full
            assign mixed_d = mix_columns(shifted_d);
            // matrix rows sum to 1 in GF(2^8): each mixed column keeps its byte XOR
            for (genvar c = 0; c < NUM_COLS; c++) begin : g_par
                always_comb begin
                    assert_mix_parity_R8: assert (
                        fold_word(mixed_d[BLOCK_W-1-WORD_W*c -: WORD_W]) ==
                        fold_word(shifted_d[BLOCK_W-1-WORD_W*c -: WORD_W]))
                    else $error("column mixing broke column parity");
                end
            end
        end
    endgenerate

    assign state_o = mixed_d ^ rkey_i;

endmodule

// File: rtl/aes128_pipe_enc.sv
module aes128_pipe_enc
    import aes128_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [127:0] in_key,
    input  logic [127:0] in_text,
    output logic         out_valid,
    output logic [127:0] out_text
);

    stage_t stage_q [0:NUM_ROUNDS];
    stage_t stage_d [0:NUM_ROUNDS];
    block_t rkey_nx [1:NUM_ROUNDS];
    block_t state_nx[1:NUM_ROUNDS];

    generate
        for (genvar r = 1; r <= NUM_ROUNDS; r++) begin : g_round
            aes128_key_step #(
                .RCON (rcon_of(r))
            ) u_key (
                .key_i (stage_q[r-1].rkey),
                .key_o (rkey_nx[r])
            );
            aes128_round #(
                .LAST (r == NUM_ROUNDS)
            ) u_rnd (
                .state_i (stage_q[r-1].state),
                .rkey_i  (rkey_nx[r]),
                .state_o (state_nx[r])
            );
        end
    endgenerate

    always_comb begin
        stage_d[0].vld   = in_valid;
        stage_d[0].state = in_text ^ in_key;
        stage_d[0].rkey  = in_key;
        for (int r = 1; r <= NUM_ROUNDS; r++) begin
            stage_d[r].vld   = stage_q[r-1].vld;
            stage_d[r].state = state_nx[r];
            stage_d[r].rkey  = rkey_nx[r];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r <= NUM_ROUNDS; r++) stage_q[r] <= '0;
        end else begin
            for (int r = 0; r <= NUM_ROUNDS; r++) stage_q[r] <= stage_d[r];
        end
    end

    assign out_valid = stage_q[NUM_ROUNDS].vld;
    assign out_text  = stage_q[NUM_ROUNDS].state;

    // edges seen since reset, saturating at the pipeline depth
    localparam int CNT_W = $clog2(PIPE_LAT + 1);
    localparam logic [CNT_W-1:0] LAT_CNT = CNT_W'(PIPE_LAT);
    logic [CNT_W-1:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   since_rst_q <= '0;
        else if (since_rst_q != LAT_CNT) since_rst_q <= since_rst_q + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q != LAT_CNT) |-> !out_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == LAT_CNT) |-> (out_valid == $past(in_valid, PIPE_LAT)));

    assert_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == LAT_CNT && $past(since_rst_q) == LAT_CNT &&
         $past(in_valid, PIPE_LAT) && $past(in_valid, PIPE_LAT + 1))
        |-> (out_valid && $past(out_valid)));

    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == LAT_CNT && !$past(in_valid, PIPE_LAT)) |-> !out_valid);

endmodule

// File: tb/tb_aes128_pipe_enc.sv
module tb_aes128_pipe_enc;

    localparam int LATENCY = 11;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_key;
    logic [127:0] in_text;
    logic         out_valid;
    logic [127:0] out_text;

    always #5 clk = ~clk;

    aes128_pipe_enc dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_key    (in_key),
        .in_text   (in_text),
        .out_valid (out_valid),
        .out_text  (out_text)
    );

    int unsigned cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [127:0] ct;
        int unsigned  due;
        string        req;
    } exp_t;
    exp_t sb[$];

    logic [7:0] ref_sbox [256];

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int j = 14; j >= 8; j--) if (prod[j]) prod = prod ^ (16'h011b << (j - 8));
        return prod[7:0];
    endfunction

    function automatic logic [127:0] ref_encrypt(input logic [127:0] key, input logic [127:0] pt);
        logic [31:0] w [44];
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [31:0] tmp;
        logic [7:0]  rc;
        logic [7:0]  a0, a1, a2, a3;
        logic [127:0] o;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        rc = 8'h01;
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {ref_sbox[tmp[23:16]], ref_sbox[tmp[15:8]], ref_sbox[tmp[7:0]],
                       ref_sbox[tmp[31:24]]} ^ {rc, 24'h0};
                rc = ref_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int i = 0; i < 16; i++) t[i] = ref_sbox[s[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
            if (rnd != 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = ref_mul(a0, 8'h02) ^ ref_mul(a1, 8'h03) ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ ref_mul(a1, 8'h02) ^ ref_mul(a2, 8'h03) ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ ref_mul(a2, 8'h02) ^ ref_mul(a3, 8'h03);
                    s[4*c+3] = ref_mul(a0, 8'h03) ^ a1 ^ a2 ^ ref_mul(a3, 8'h02);
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*rnd + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic send(input logic [127:0] key, input logic [127:0] pt,
                        input logic [127:0] ct, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_key   = key;
        in_text  = pt;
        sb.push_back('{ct: ct, due: cyc + LATENCY, req: req});
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_key   = rnd128();   // junk that must be ignored (R4)
            in_text  = rnd128();
        end
    endtask

    // monitor: pops expected results as the engine produces them
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            automatic bit exp_v = (sb.size() > 0) && (sb[0].due == cyc);
            automatic exp_t it;
            check(out_valid === exp_v, exp_v ? "R2" : "R4", "out_valid",
                  128'(out_valid), 128'(exp_v));
            if (exp_v) begin
                it = sb.pop_front();
                if (out_valid === 1'b1)
                    check(out_text === it.ct, it.req, "ciphertext", out_text, it.ct);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] ka, kb, k, p;
        logic [7:0] inv, aff;
        for (int v = 0; v < 256; v++) begin
            inv = 8'h00;
            for (int c = 1; c < 256; c++)
                if (ref_mul(8'(v), 8'(c)) == 8'h01) inv = 8'(c);
            for (int b = 0; b < 8; b++)
                aff[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8]
                         ^ ((8'h63 >> b) & 8'h01) != 0;
            ref_sbox[v] = aff;
        end

        rst_n = 1'b0; in_valid = 1'b0; in_key = rnd128(); in_text = rnd128();
        // R1: outputs quiet during reset, even with junk on the inputs
        repeat (4) begin
            @(negedge clk);
            in_valid = 1'b1;
            check(out_valid === 1'b0, "R1", "out_valid in reset", 128'(out_valid), 128'(0));
            check(out_text === '0, "R1", "out_text in reset", out_text, '0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // reference model self-check against a published vector
        check(ref_encrypt(128'h2b7e151628aed2a6abf7158809cf4f3c,
                          128'h3243f6a8885a308d313198a2e0370734) ===
              128'h3925841d02dc09fbdc118597196a0b32, "R5", "bench model",
              ref_encrypt(128'h2b7e151628aed2a6abf7158809cf4f3c,
                          128'h3243f6a8885a308d313198a2e0370734),
              128'h3925841d02dc09fbdc118597196a0b32);

        // R5 / R7 / R8: known answers back to back under different keys
        send(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
             128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5");
        send(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
             128'h3925841d02dc09fbdc118597196a0b32, "R7");
        send('0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R8");
        send({16{8'hff}}, '0, ref_encrypt({16{8'hff}}, '0), "R7");
        idle(14);

        // R6: alternating keys, every clock
        ka = rnd128();
        kb = rnd128();
        for (int i = 0; i < 24; i++) begin
            k = (i % 2 == 0) ? ka : kb;
            p = rnd128();
            send(k, p, ref_encrypt(k, p), "R6");
        end
        idle(2);

        // R4: gapped traffic with junk on the data pins in the gaps
        for (int i = 0; i < 12; i++) begin
            k = rnd128();
            p = rnd128();
            send(k, p, ref_encrypt(k, p), "R4");
            idle(1 + (i % 4));
        end

        // R3: long full-rate stream of fresh keys
        for (int i = 0; i < 64; i++) begin
            k = rnd128();
            p = rnd128();
            send(k, p, ref_encrypt(k, p), "R3");
        end
        idle(LATENCY + 4);

        done = 1'b1;
        check(sb.size() == 0, "R2", "results left over", 128'(sb.size()), 128'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule